// File: doc/BRIEF.md
# Two-Phase Preemptable Child Sequencer

This controller runs two short child behaviours one after the other on a single clock. While a child is active, the controller steers a shared data output from that child and reports which phase it is in. Each child sits inside a region that is cut short when the `switch_i` input is high. The first child's region and the second child's region are separated by a one-cycle resting point.

A parent block drives the sequencer through a control context:
- start (restart),
- preempt-at-start,
- abort,
- suspend,
- an output gate that stops the block from writing its data outputs.

The sequencer answers with three status flags: instantaneous, inside and terminate. Data outputs are memorised. A value written in a cycle appears in that same cycle and then holds until the next write. This lets several mutually exclusive sequencers take turns on one output under their parents' gates.

For test purposes, each child acts for exactly two cycles:
- On its starting cycle and on the following cycle it writes the output.
- The first child writes `data_i + 1`.
- The second child writes the bitwise inverse of `data_i`.
- A child finishes on its second cycle.

Top module: `dual_phase_sequencer`

## Requirements
- R1: In a cycle with start high and preempt low, mode_o reads 1 and data_o reads data_i+1 in that same cycle, and the first child is inside from the next cycle on.
- R2: With no context inputs and switch low, the cycles after start run as follows. The first child's second cycle writes data_i+1. The pause cycle writes mode 2 and the inverse of data_i. The second child's second cycle writes the inverse of data_i with terminate high. After that the block is idle.
- R3: Switch high in the first child's second cycle suppresses that cycle's write, and control still reaches the pause in the next cycle.
- R4: Switch high in the second child's second cycle suppresses that cycle's write, and terminate is still asserted in that cycle.
- R5: Switch is ignored in the start cycle, in the pause cycle and while idle. Suspend and abort are ignored while idle.
- R6: Suspend high (start low) freezes the control position and suppresses all writes. Execution resumes from the same position in the first cycle with suspend low.
- R7: When suspend and abort are both high, suspension wins and nothing is aborted.
- R8: Abort with the gate high writes nothing in that cycle. Abort with the gate low performs that cycle's writes. In both cases the block is idle in the next cycle and terminate stays low.
- R9: While the gate is high, data_o and mode_o keep their previous values, but control still advances and terminate is still reported.
- R10: Start together with abort on a running block abandons the current position and begins the first child again in the same cycle.
- R11: Start clears data_o and mode_o to 0 before that cycle's writes. Start with preempt high writes nothing, so both read 0 and the block stays idle.
- R12: inside_o is the OR of the two children's inside flags and is therefore 0 in the pause cycle. instant_o is always 0.
- R13: After reset data_o, mode_o and all flags are 0. In cycles without a write, data_o and mode_o hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start or restart the sequence |
| preempt_i | input | 1 | Preempt the starting cycle (with start) |
| abort_i | input | 1 | Abort a running sequence |
| susp_i | input | 1 | Suspend; wins over abort |
| gate_i | input | 1 | High: block must not write data_o or mode_o |
| switch_i | input | 1 | Cuts short the currently running child |
| data_i | input | DW | Data read by the children |
| data_o | output | DW | Memorised shared data output |
| mode_o | output | 2 | Phase: 0 none, 1 first child, 2 second child |
| instant_o | output | 1 | Instantaneous flag, always 0 |
| inside_o | output | 1 | A child currently holds control |
| terminate_o | output | 1 | The second child is finishing this cycle |

## Verification
The following properties are checked on every cycle:
- At most one control position is occupied.
- The pause never reports inside.
- A started child is inside one cycle later.
- A suspended position stays frozen.
- An abort without suspend leaves the block idle.
- A gated cycle leaves both data outputs unchanged.

The bench's scenarios cover the rest:
- The exact values written in each phase.
- Where switch is ignored and where it takes effect.
- The weak and strong variants of abort.
- Restart over a running sequence.
- Preempted start.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int unsigned PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_NONE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/dps_child.sv
// One two-cycle child wrapped in a switch-abortable region.
module dps_child (
  input  logic clk,
  input  logic rst_n,
  input  logic go_act_i,   // child acts in its starting cycle
  input  logic go_keep_i,  // child enters its second cycle
  input  logic clr_i,      // outer restart
  input  logic susp_i,
  input  logic abort_i,
  input  logic switch_i,
  output logic inside_o,
  output logic act_o,
  output logic fin_o       // finished normally or cut by switch
);
  logic in_q;

  assign inside_o = in_q;
  // Second cycle acts unless frozen or cut by switch (strong, pre-action).
  assign act_o    = go_act_i | (in_q & ~clr_i & ~susp_i & ~switch_i);
  assign fin_o    = in_q & ~clr_i & ~susp_i & ~abort_i;

  always_ff @(posedge clk) begin
    if (!rst_n) in_q <= 1'b0;
    else        in_q <= go_keep_i | (in_q & ~clr_i & susp_i);
  end

  // R2: a child never stays past its second cycle unless frozen
  assert_child_leave_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q && !clr_i && !susp_i && !go_keep_i) |=> !in_q);

  // R6: suspension keeps the child in place
  assert_child_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q && susp_i && !clr_i) |=> in_q);
endmodule

// File: rtl/dps_hold.sv
// Memorised output register: written value is visible in the same cycle.
module dps_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_r;

  assign q_o = wr_i ? d_i : (clr_i ? '0 : held_r);

  always_ff @(posedge clk) begin
    if (!rst_n) held_r <= '0;
    else        held_r <= q_o;
  end
endmodule

// File: rtl/dual_phase_sequencer.sv
module dual_phase_sequencer #(
  parameter int unsigned DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       preempt_i,
  input  logic                       abort_i,
  input  logic                       susp_i,
  input  logic                       gate_i,
  input  logic                       switch_i,
  input  logic [DW-1:0]              data_i,
  output logic [DW-1:0]              data_o,
  output logic [dps_pkg::PHASE_W-1:0] mode_o,
  output logic                       instant_o,
  output logic                       inside_o,
  output logic                       terminate_o
);
  import dps_pkg::*;

  localparam int unsigned POS_W = 3;

  function automatic logic [DW-1:0] first_val(input logic [DW-1:0] x);
    return x + DW'(1);
  endfunction

  function automatic logic [DW-1:0] second_val(input logic [DW-1:0] x);
    return ~x;
  endfunction

  // Named internal events
  logic c1_go, c2_go_act, c2_go_keep;
  logic c1_in, c1_act, c1_fin;
  logic c2_in, c2_act, c2_fin;
  logic pause_q, live_q;
  logic wr_data, wr_mode;
  logic [DW-1:0] data_val;
  phase_e mode_val;
  logic [POS_W-1:0] pos_vec;

  assign c1_go      = start_i & ~preempt_i;
  assign c2_go_act  = ~start_i & pause_q & ~susp_i;
  assign c2_go_keep = c2_go_act & ~abort_i;

  dps_child u_first (
    .clk(clk), .rst_n(rst_n),
    .go_act_i(c1_go), .go_keep_i(c1_go), .clr_i(start_i),
    .susp_i(susp_i), .abort_i(abort_i), .switch_i(switch_i),
    .inside_o(c1_in), .act_o(c1_act), .fin_o(c1_fin)
  );

  dps_child u_second (
    .clk(clk), .rst_n(rst_n),
    .go_act_i(c2_go_act), .go_keep_i(c2_go_keep), .clr_i(start_i),
    .susp_i(susp_i), .abort_i(abort_i), .switch_i(switch_i),
    .inside_o(c2_in), .act_o(c2_act), .fin_o(c2_fin)
  );

  // Resting point between the two regions
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_q <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      pause_q <= ~start_i & ((pause_q & susp_i) | c1_fin);
      live_q  <= 1'b1;
    end
  end

  assign wr_data  = ~gate_i & (c1_act | c2_act);
  assign data_val = c1_act ? first_val(data_i) : second_val(data_i);
  assign wr_mode  = ~gate_i & (c1_go | c2_go_act);
  assign mode_val = c1_go ? PH_FIRST : PH_SECOND;

  dps_hold #(.W(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i),
    .wr_i(wr_data), .d_i(data_val), .q_o(data_o)
  );

  dps_hold #(.W(PHASE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i),
    .wr_i(wr_mode), .d_i(mode_val), .q_o(mode_o)
  );

  assign instant_o   = 1'b0;
  assign inside_o    = c1_in | c2_in;
  assign terminate_o = c2_fin;
  assign pos_vec     = {c1_in, pause_q, c2_in};

  // R12: control occupies at most one position
  assert_one_pos_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pos_vec));

  // R12: the pause is outside both children
  assert_pause_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pause_q |-> !inside_o);

  // R1: a non-preempted start puts the first child inside next cycle
  assert_start_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !preempt_i) |=> (c1_in && !pause_q && !c2_in));

  // R6 / R7: suspension freezes the position, even against abort
  assert_susp_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_i && !start_i) |=> (pos_vec == $past(pos_vec)));

  // R8: abort without suspension leaves the block idle
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && !susp_i && !start_i) |=> (pos_vec == '0));

  // R9: gated cycles leave the shared outputs untouched
  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && gate_i && !start_i) |->
      (data_o == $past(data_o) && mode_o == $past(mode_o)));

  // R4: terminate only from the second child's second cycle
  assert_term_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    terminate_o |-> (c2_in && !c1_in));
endmodule

// File: tb/dual_phase_sequencer_tb.sv
`timescale 1ns/1ps
module dual_phase_sequencer_tb_top;
  localparam int DW = 8;
  localparam int NV = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, preempt_i = 0, abort_i = 0, susp_i = 0, gate_i = 0, switch_i = 0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic [1:0] mode_o;
  logic instant_o, inside_o, terminate_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk; // 125 MHz

  dual_phase_sequencer #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .preempt_i(preempt_i),
    .abort_i(abort_i), .susp_i(susp_i), .gate_i(gate_i), .switch_i(switch_i),
    .data_i(data_i), .data_o(data_o), .mode_o(mode_o), .instant_o(instant_o),
    .inside_o(inside_o), .terminate_o(terminate_o)
  );

  // {start,preempt,abort,susp,gate,switch}, data_i, exp data_o, exp mode, exp inside, exp terminate
  localparam logic [25:0] VEC [NV] = '{
    {6'b100000, 8'd10, 8'd11,  2'd1, 1'b0, 1'b0}, // 0  R1 start
    {6'b000000, 8'd20, 8'd21,  2'd1, 1'b1, 1'b0}, // 1  R2 child1 second
    {6'b000000, 8'd30, 8'd225, 2'd2, 1'b0, 1'b0}, // 2  R2 pause
    {6'b000000, 8'd40, 8'd215, 2'd2, 1'b1, 1'b1}, // 3  R2 child2 end
    {6'b000000, 8'd50, 8'd215, 2'd2, 1'b0, 1'b0}, // 4  R13 hold idle
    {6'b100001, 8'd1,  8'd2,   2'd1, 1'b0, 1'b0}, // 5  R5 switch at start
    {6'b000001, 8'd2,  8'd2,   2'd1, 1'b1, 1'b0}, // 6  R3 switch cuts child1
    {6'b000001, 8'd3,  8'd252, 2'd2, 1'b0, 1'b0}, // 7  R5 switch at pause
    {6'b000001, 8'd4,  8'd252, 2'd2, 1'b1, 1'b1}, // 8  R4 switch cuts child2
    {6'b000000, 8'd5,  8'd252, 2'd2, 1'b0, 1'b0}, // 9  R13 idle
    {6'b100000, 8'd6,  8'd7,   2'd1, 1'b0, 1'b0}, // 10 R1
    {6'b001100, 8'd8,  8'd7,   2'd1, 1'b1, 1'b0}, // 11 R7 susp beats abort
    {6'b000100, 8'd9,  8'd7,   2'd1, 1'b1, 1'b0}, // 12 R6 frozen
    {6'b000000, 8'd12, 8'd13,  2'd1, 1'b1, 1'b0}, // 13 R6 resumed
    {6'b001100, 8'd14, 8'd13,  2'd1, 1'b0, 1'b0}, // 14 R7 at pause
    {6'b000000, 8'd15, 8'd240, 2'd2, 1'b0, 1'b0}, // 15 R6 pause resumed
    {6'b000100, 8'd16, 8'd240, 2'd2, 1'b1, 1'b0}, // 16 R6 child2 frozen
    {6'b000000, 8'd17, 8'd238, 2'd2, 1'b1, 1'b1}, // 17 R6 resumed end
    {6'b100000, 8'd20, 8'd21,  2'd1, 1'b0, 1'b0}, // 18 R1
    {6'b001010, 8'd22, 8'd21,  2'd1, 1'b1, 1'b0}, // 19 R8 strong abort
    {6'b000000, 8'd23, 8'd21,  2'd1, 1'b0, 1'b0}, // 20 R8 idle
    {6'b100000, 8'd30, 8'd31,  2'd1, 1'b0, 1'b0}, // 21 R8 setup
    {6'b001000, 8'd32, 8'd33,  2'd1, 1'b1, 1'b0}, // 22 R8 weak abort
    {6'b000000, 8'd33, 8'd33,  2'd1, 1'b0, 1'b0}, // 23 R8 idle
    {6'b100000, 8'd40, 8'd41,  2'd1, 1'b0, 1'b0}, // 24 R8 setup
    {6'b000000, 8'd41, 8'd42,  2'd1, 1'b1, 1'b0}, // 25 R8 setup
    {6'b001000, 8'd50, 8'd205, 2'd2, 1'b0, 1'b0}, // 26 R8 weak abort at pause
    {6'b000000, 8'd51, 8'd205, 2'd2, 1'b0, 1'b0}, // 27 R8 idle
    {6'b100010, 8'd60, 8'd0,   2'd0, 1'b0, 1'b0}, // 28 R9 gated start
    {6'b000010, 8'd61, 8'd0,   2'd0, 1'b1, 1'b0}, // 29 R9 gated child1
    {6'b000000, 8'd62, 8'd193, 2'd2, 1'b0, 1'b0}, // 30 R9 pause writes
    {6'b000010, 8'd63, 8'd193, 2'd2, 1'b1, 1'b1}, // 31 R9 gated end
    {6'b100000, 8'd70, 8'd71,  2'd1, 1'b0, 1'b0}, // 32 R2
    {6'b000000, 8'd71, 8'd72,  2'd1, 1'b1, 1'b0}, // 33 R2
    {6'b000000, 8'd72, 8'd183, 2'd2, 1'b0, 1'b0}, // 34 R2
    {6'b101000, 8'd80, 8'd81,  2'd1, 1'b1, 1'b0}, // 35 R10 restart in child2
    {6'b000000, 8'd81, 8'd82,  2'd1, 1'b1, 1'b0}, // 36 R10 child1 again
    {6'b110000, 8'd90, 8'd0,   2'd0, 1'b0, 1'b0}, // 37 R11 preempted start
    {6'b000000, 8'd91, 8'd0,   2'd0, 1'b0, 1'b0}, // 38 R11 stays idle
    {6'b001101, 8'd99, 8'd0,   2'd0, 1'b0, 1'b0}  // 39 R5 idle ignores
  };

  function automatic string req_of(input int k);
    if (k == 0 || k == 10 || k == 18) return "R1";
    if (k <= 3 || (k >= 32 && k <= 34)) return "R2";
    if (k == 4 || k == 9) return "R13";
    if (k == 5 || k == 7 || k == 39) return "R5";
    if (k == 6) return "R3";
    if (k == 8) return "R4";
    if (k == 11 || k == 14) return "R7";
    if (k <= 17) return "R6";
    if (k <= 27) return "R8";
    if (k <= 31) return "R9";
    if (k <= 36) return "R10";
    return "R11";
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual o=%0d mode=%0d inst=%0b ins=%0b trm=%0b expected o=%0d mode=%0d inst=%0b ins=%0b trm=%0b",
        req, act[19:12], act[11:10], act[9], act[8], act[7],
        exp[19:12], exp[11:10], exp[9], exp[8], exp[7]);
    end
  endtask

  function automatic logic [19:0] pack_out();
    return {data_o, mode_o, instant_o, inside_o, terminate_o, 7'd0};
  endfunction

  task automatic drive(input logic [5:0] c, input logic [DW-1:0] d);
    {start_i, preempt_i, abort_i, susp_i, gate_i, switch_i} = c;
    data_i = d;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R13: reset state
    check("R13", pack_out(), 20'd0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k][25:20], VEC[k][19:12]);
      #2;
      // R12: instant_o expected 0 in every row
      check(req_of(k), pack_out(), {VEC[k][11:0], 1'b0, VEC[k][1:0], 7'd0} >> 0 == 0 ? 20'd0 :
            {VEC[k][11:4], VEC[k][3:2], 1'b0, VEC[k][1], VEC[k][0], 7'd0});
    end

    // R12: pause is outside both children, instant stays 0
    @(negedge clk); drive(6'b100000, 8'd5);
    @(negedge clk); drive(6'b000000, 8'd6);
    @(negedge clk); drive(6'b000000, 8'd7);
    #2;
    check("R12", {7'd0, instant_o, inside_o, 11'd0}, 20'd0);

    // R13: reset in the middle of a run returns to all zero
    @(negedge clk); drive(6'b000000, 8'd8);
    rst_n = 1'b0;
    @(negedge clk); drive(6'b000000, 8'd9);
    rst_n = 1'b1;
    #2;
    check("R13", pack_out(), 20'd0);

    // R5: switch while idle writes nothing
    @(negedge clk); drive(6'b000001, 8'd44);
    #2;
    check("R5", pack_out(), 20'd0);

    @(negedge clk); drive(6'b000000, 8'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule